// File: doc/BRIEF.md
# SPI Flash Fast-Read Responder

This block is the target side of a serial flash read port that handles only the fast-read transaction. The host lowers the chip select and sends three things on the serial input. The first is the 8-bit command `0x0B`. The second is a 24-bit start address. The third is one filler byte whose bit values do not matter. After that the block returns bytes from its storage array on the serial output, most significant bit first. It steps to the next location after every byte, and it keeps going until the chip select goes high again.

The block runs on a system clock that is at least four times faster than the serial clock. The serial clock, chip select and data input pass through synchronisers, and their edges are detected in the system domain. The output data and its enable come from registers, and an external tri-state buffer uses them to drive the SO line. Both idle clock polarities are accepted (SPI modes 0 and 3). Input bits are taken on rising serial-clock edges and output bits change on falling edges.

The storage is a synchronous byte array of `2**MEM_AW` bytes, filled through a plain write port before any reads. The address pointer is `ADDR_W` bits wide (19 by default, a 512 KiB space). When the array is smaller than that space, it repeats across it.

Top module: `spi_fr_responder`

## Requirements
- R1: After reset, and while the chip select is high, `so_en` is 0.
- R2: Bits are sampled on rising SCK, MSB first. Clocks 0 to 7 carry the command, which must be `0x0B`. Clocks 8 to 31 carry the address A23..A0. Clocks 32 to 39 carry the filler byte, and its bit values have no effect on the output.
- R3: Bit 7 of the first data byte is on `so_data` after the falling SCK edge that follows rising clock 39, so the host can sample it on rising clock 40. Each following bit and byte takes one more clock, MSB first.
- R4: `so_en` stays 0 through all 40 header clocks and is 1 for every data bit.
- R5: Byte k of the stream (counting from 0) is the storage byte at start address + k. The stream has no length limit.
- R6: The pointer wraps from `2**ADDR_W - 1` back to 0, so with the default width the byte after 0x7FFFF comes from 0x00000.
- R7: Only address bits below `ADDR_W` select a location, and the upper address bits are ignored.
- R8: If the command is anything other than `0x0B`, `so_en` stays 0 until the chip select rises.
- R9: A rising chip select at any point ends the output by clearing `so_en`, and it returns decoding to the command stage, so the next transaction behaves normally.
- R10: A transaction works the same whether SCK idles low (mode 0) or high (mode 3) when the chip select falls.
- R11: A write with `ld_en` high stores `ld_data` at location `ld_addr`, and reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| so_data | output | 1 | Serial output data bit |
| so_en | output | 1 | Output enable for the SO tri-state buffer |
| ld_en | input | 1 | Storage write strobe |
| ld_addr | input | MEM_AW | Storage write location |
| ld_data | input | 8 | Storage write byte |

## Verification
Each input edge reaches the logic after two synchroniser stages plus one edge-detect register, and `so_data` and `so_en` settle about four system clocks after the falling SCK edge that moves them. The bench holds each SCK half period for eight system clocks and reads the output on the last of those clocks, just before it drives the next rising edge, the same moment a host would sample. After a chip-select rise it waits sixteen clocks before it checks that the enable is cleared. A small configuration (`ADDR_W = MEM_AW = 11`) lets the bench see the wrap and the dropped upper address bits directly, and the bench computes expected bytes from the arithmetic fill pattern.

// File: rtl/spi_fr_pkg.sv
// Package: constants and the state type shared by the fast-read responder.
// Assumes one command byte, a 24-bit address and one filler byte per header.
package spi_fr_pkg;
    localparam int          CMD_BITS   = 8;
    localparam int          ADR_BITS   = 24;
    localparam int          FILL_BITS  = 8;
    localparam int          HDR_BITS   = CMD_BITS + ADR_BITS + FILL_BITS;
    localparam int          CNT_W      = $clog2(HDR_BITS);
    localparam logic [7:0]  CMD_FAST   = 8'h0B;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADR,
        ST_FILL,
        ST_DATA,
        ST_IGN
    } fr_state_t;
endpackage

// File: rtl/spi_fr_sync.sv
// Module: multi-stage synchroniser with rise/fall detection for a group of
// asynchronous single-bit inputs. Assumes each input stays stable for at
// least two system clocks between edges.
module spi_fr_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic [WIDTH-1:0]             prev;

    // Shift the raw inputs through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    // Keep the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= pipe[STAGES-1];
    end

    assign lvl = pipe[STAGES-1];

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_edge
            assign rise[g] = lvl[g] & ~prev[g];
            assign fall[g] = ~lvl[g] & prev[g];
        end
    endgenerate
endmodule

// File: rtl/spi_fr_mem.sv
// Module: byte storage with one synchronous write port and one synchronous
// read port (one clock of read latency). The contents have no reset; the
// owner fills them before use.
module spi_fr_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] store [DEPTH];

    // Write a byte and/or read a byte, each on request.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/spi_fr_responder.sv
// Module: target-side fast-read engine. Decodes command, address and filler
// from SI on rising SCK, then streams storage bytes on SO on falling SCK with
// an auto-incrementing, wrapping pointer. Assumes clk >= 4x SCK, and
// MEM_AW <= ADDR_W <= 24.
module spi_fr_responder
    import spi_fr_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so_data,
    output logic              so_en,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data
);
    localparam int              SR_W     = ADR_BITS + CMD_BITS - 1;
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(CMD_BITS + ADR_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BITS - 1);

    logic [2:0] s_lvl, s_rise, s_fall;
    logic       cs_s, si_s, sck_rise, sck_fall;

    fr_state_t          st;
    logic [CNT_W-1:0]   hdr_cnt;
    logic [SR_W-1:0]    hdr_sr;
    logic [SR_W:0]      hdr_word;
    logic [ADDR_W-1:0]  ptr;
    logic               rd_go, rd_vld;
    logic [7:0]         rdata, nxt, sh;
    logic [2:0]         dcnt;

    spi_fr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, si}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign cs_s     = s_lvl[2];
    assign si_s     = s_lvl[0];
    assign sck_rise = s_rise[1];
    assign sck_fall = s_fall[1];
    assign hdr_word = {hdr_sr, si_s};

    // Header decoder: count rising edges and step through the phases.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            st      <= ST_CMD;
            hdr_cnt <= '0;
            hdr_sr  <= '0;
        end else if (sck_rise && (st == ST_CMD || st == ST_ADR || st == ST_FILL)) begin
            hdr_sr  <= hdr_word[SR_W-1:0];
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_cnt == LAST_CMD)
                st <= (hdr_word[CMD_BITS-1:0] == CMD_FAST) ? ST_ADR : ST_IGN;
            else if (hdr_cnt == LAST_ADR)
                st <= ST_FILL;
            else if (hdr_cnt == LAST_HDR)
                st <= ST_DATA;
        end
    end

    // Pointer and prefetch: load the start address, then fetch one byte ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            rd_go  <= 1'b0;
            rd_vld <= 1'b0;
            nxt    <= '0;
        end else begin
            rd_go  <= 1'b0;
            rd_vld <= rd_go;
            if (rd_vld) begin
                nxt <= rdata;
                ptr <= ptr + 1'b1;
            end
            if (!cs_s && sck_rise && st == ST_ADR && hdr_cnt == LAST_ADR) begin
                ptr   <= hdr_word[ADDR_W-1:0];
                rd_go <= 1'b1;
            end else if (!cs_s && sck_fall && st == ST_DATA && dcnt == 3'd0) begin
                rd_go <= 1'b1;
            end
        end
    end

    // Output shifter: present one bit per falling SCK while streaming.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            so_en   <= 1'b0;
            so_data <= 1'b0;
            sh      <= '0;
            dcnt    <= '0;
        end else if (sck_fall && st == ST_DATA) begin
            so_en <= 1'b1;
            dcnt  <= dcnt + 1'b1;
            if (dcnt == 3'd0) begin
                so_data <= nxt[7];
                sh      <= {nxt[6:0], 1'b0};
            end else begin
                so_data <= sh[7];
                sh      <= {sh[6:0], 1'b0};
            end
        end
    end

    spi_fr_mem #(
        .AW(MEM_AW)
    ) u_mem (
        .clk  (clk),
        .we   (ld_en),
        .waddr(ld_addr),
        .wdata(ld_data),
        .re   (rd_go),
        .raddr(ptr[MEM_AW-1:0]),
        .rdata(rdata)
    );
endmodule

// File: rtl/spi_fr_checker.sv
// Module: assertion checker bound to the responder. Watches the synchronised
// controls, the decoder state and the output registers.
module spi_fr_checker
    import spi_fr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input logic      sck_fall,
    input logic      so_en,
    input logic      so_data,
    input fr_state_t st
);
    // R9 / R1: a deselected bus leaves the output disabled one clock later.
    a_r9_deselect_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_en);

    // R4 / R8: the output is enabled only while streaming data.
    a_r4_oe_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> st == ST_DATA);

    // R3: the output bit moves only after a falling SCK.
    a_r3_bit_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_s) |=> $stable(so_data));

    // R8: a rejected command stays rejected until deselect.
    a_r8_ignore_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN && !cs_s) |=> st == ST_IGN);

    // R2: the decoder is back in the command stage while deselected.
    a_r2_restart_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st == ST_CMD || cs_s == 1'b0));
endmodule

bind spi_fr_responder spi_fr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sck_fall(sck_fall),
    .so_en   (so_en),
    .so_data (so_data),
    .st      (st)
);

// File: tb/spi_fr_responder_tb.sv
module spi_fr_responder_tb;
    localparam int AW  = 11;
    localparam int H   = 8;
    localparam int MSK = (1 << AW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so_data, so_en;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    spi_fr_responder #(.ADDR_W(AW), .MEM_AW(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_data(so_data), .so_en(so_en),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));

    function automatic logic [7:0] pat(input int a);
        return 8'(((a & MSK) * 37 + 11) ^ ((a & MSK) >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic r, output logic e);
        sck = 1'b0; si = b;
        waitc(H);
        r = so_data; e = so_en;
        sck = 1'b1;
        waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] v, inout logic any_en);
        logic r, e;
        for (int i = 7; i >= 0; i--) begin
            bit_x(v[i], r, e);
            any_en = any_en | e;
        end
    endtask

    task automatic get_byte(output logic [7:0] v, output logic all_en);
        logic r, e;
        all_en = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b0, r, e);
            v[i] = r;
            all_en = all_en & e;
        end
    endtask

    task automatic sel(input bit mode3);
        sck = mode3; waitc(H);
        cs_n = 1'b0; waitc(H);
    endtask

    task automatic desel(input bit mode3);
        if (!mode3) sck = 1'b0;
        waitc(H);
        cs_n = 1'b1;
        waitc(2 * H);
    endtask

    task automatic header(input logic [7:0] cmd, input logic [23:0] a,
                          input logic [7:0] fill, output logic any_en);
        any_en = 1'b0;
        send_byte(cmd, any_en);
        send_byte(a[23:16], any_en);
        send_byte(a[15:8], any_en);
        send_byte(a[7:0], any_en);
        send_byte(fill, any_en);
    endtask

    // R2 R3 R4 R5 R6 R7 R10: full read with computed expected bytes.
    task automatic read_tx(input logic [23:0] a, input int n, input bit mode3,
                           input logic [7:0] fill, input string tag);
        logic any_en, all_en;
        logic [7:0] v;
        sel(mode3);
        header(8'h0B, a, fill, any_en);
        chk(!any_en, {"R4 header oe ", tag}, any_en, 0);
        for (int k = 0; k < n; k++) begin
            get_byte(v, all_en);
            chk(all_en, {"R4 data oe ", tag}, all_en, 1);
            chk(v == pat(int'(a) + k), {"R3 R5 data ", tag}, v, pat(int'(a) + k));
        end
        desel(mode3);
        chk(so_en == 1'b0, {"R9 oe after deselect ", tag}, so_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic any_en, all_en;
        logic [7:0] v;
        waitc(4);
        rst_n = 1'b1;
        waitc(2);
        chk(so_en == 1'b0, "R1 reset oe", so_en, 0);

        // R11: fill storage with the arithmetic pattern.
        for (int a = 0; a <= MSK; a++) begin
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = pat(a);
            waitc(1);
        end
        ld_en = 1'b0;
        waitc(4);

        // R2 R7 R10: sweep start addresses (upper bits set), modes and fill values.
        for (int k = 0; k < 24; k++)
            read_tx(24'((k * 32'h0013579B) ^ (k << 20)), 3, k[0], 8'(k * 29), "sweep");

        // R5: long continuous stream.
        read_tx(24'h000100, 12, 1'b0, 8'hFF, "long");
        // R6: wrap at the top of the space, with R7 upper bits set.
        read_tx(24'h0007FD, 6, 1'b0, 8'h00, "wrap");
        read_tx(24'hFFFFFF, 3, 1'b1, 8'hA5, "wrap R7");

        // R8: foreign command keeps the output disabled.
        sel(1'b0);
        header(8'h03, 24'h000010, 8'h00, any_en);
        chk(!any_en, "R8 header oe", any_en, 0);
        for (int k = 0; k < 3; k++) begin
            get_byte(v, all_en);
            chk(!all_en && so_en == 1'b0, "R8 stays disabled", so_en, 0);
        end
        desel(1'b0);
        read_tx(24'h000010, 2, 1'b0, 8'h00, "R9 after bad cmd");

        // R9: abort mid-byte, then a fresh transaction.
        sel(1'b1);
        header(8'h0B, 24'h000200, 8'h3C, any_en);
        get_byte(v, all_en);
        chk(v == pat(32'h200), "R9 first byte before abort", v, pat(32'h200));
        for (int i = 0; i < 3; i++) begin
            logic r, e;
            bit_x(1'b0, r, e);
        end
        desel(1'b1);
        chk(so_en == 1'b0, "R9 abort clears oe", so_en, 0);
        read_tx(24'h000345, 2, 1'b0, 8'h77, "R9 after abort");

        // R11: rewrite one location and read it back.
        ld_en = 1'b1; ld_addr = AW'(16'h123); ld_data = 8'h5A;
        waitc(1);
        ld_en = 1'b0;
        sel(1'b0);
        header(8'h0B, 24'h000123, 8'h00, any_en);
        get_byte(v, all_en);
        chk(v == 8'h5A, "R11 rewritten byte", v, 8'h5A);
        desel(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule